// File: doc/BRIEF.md
# DMA Channel Address and Count Sequencer

This block is the transfer datapath of a single DMA channel. Software programs a base address and a base count, plus an independent page value for the upper address bits. Each accepted transfer-done strobe moves the current address one step, up or down, and lowers the current count by one. The generated physical address joins the page value to the 16-bit current address. In byte mode the page supplies bits 23:16. In word mode the address is a word address shifted left by one, and page bit 0 is dropped.

The 16-bit address counter wraps inside its page and never carries into the page bits. A byte transfer therefore stays inside one 64 KB page, and a word transfer stays inside one 128 KB block. The programmed count is one less than the number of transfers. The strobe that finds the count at zero ends the transfer and raises terminal count. After that strobe the channel either reloads from its base values (auto-initialise) or masks itself until the next load. Arbitration and bus timing belong to other blocks.

Top module: `dma_addr_seq`

## Requirements
- R1: With `word_mode_i` low, `phys_addr_o` equals {page, current address}. Stepping up wraps the address from 0xFFFF to 0x0000, and bits 23:16 stay equal to the page.
- R2: Each accepted strobe lowers the current count by one. A programmed count of N-1 gives exactly N accepted strobes up to terminal count. Without auto-initialise, the count reads 0xFFFF after the last strobe.
- R3: With `word_mode_i` high, `phys_addr_o` equals {page[7:1], current address, 1'b0}. Page bit 0 has no effect on the output.
- R4: `tc_o` is high for exactly the one cycle after the accepted strobe that found the count at 0x0000, and low otherwise.
- R5: With `auto_init_i` high, that final strobe reloads the current address and count from the base values, and `masked_o` stays low.
- R6: With `auto_init_i` low, that final strobe sets `masked_o`. Later strobes change neither the address nor the count until the next load.
- R7: With `step_down_i` high, the address steps down and wraps from 0x0000 to 0xFFFF, and the page bits do not change.
- R8: A load copies the base address and count into both the base and current registers and clears `masked_o`. A load wins over a strobe in the same cycle. The page changes only on `page_we_i`.
- R9: After reset the address, count and page are zero, `masked_o` is high and `tc_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Load base and current address/count, unmask |
| base_addr_i | input | 16 | Programmed start address (word address in word mode) |
| base_cnt_i | input | 16 | Programmed count, transfers minus one |
| page_we_i | input | 1 | Write the page register |
| page_i | input | 8 | Page value for upper address bits |
| word_mode_i | input | 1 | 1 = 16-bit transfers with shifted address |
| step_down_i | input | 1 | 1 = address decrements |
| auto_init_i | input | 1 | 1 = reload from base at terminal count |
| xfer_done_i | input | 1 | One transfer completed this cycle |
| phys_addr_o | output | 24 | Generated physical address |
| remain_cnt_o | output | 16 | Current count |
| tc_o | output | 1 | Terminal count pulse |
| masked_o | output | 1 | Channel masked, strobes ignored |

## Verification
The assertions assume that the mode inputs hold their value across the cycle in which they are sampled, and that `xfer_done_i` is a one-cycle-per-transfer strobe. The strobe may arrive while the channel is masked; the block then ignores it. The random stimulus changes the modes only in the cycle that issues a load. It keeps most programmed counts small so that terminal count, reload and masking come up often. It also lets strobes arrive while masked and at the same time as loads and page writes. Directed cases cover the page wrap in each direction, page bit 0 in word mode, and the same-cycle load and strobe.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
    typedef enum logic {
        STEP_UP   = 1'b0,
        STEP_DOWN = 1'b1
    } step_dir_e;

    typedef enum logic {
        XFER_BYTE = 1'b0,
        XFER_WORD = 1'b1
    } xfer_width_e;
endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  step_dir_e         dir_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    // modular arithmetic: wrap stays inside the low field, no carry out
    always_comb begin
        if (dir_i == STEP_DOWN) addr_o = addr_i - ONE;
        else                    addr_o = addr_i + ONE;
    end
endmodule

// File: rtl/dma_cnt_step.sv
module dma_cnt_step #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cnt_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             zero_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_comb begin
        cnt_o  = cnt_i - ONE;
        zero_o = (cnt_i == '0);
    end
endmodule

// File: rtl/dma_phys_map.sv
module dma_phys_map
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 8
) (
    input  logic [PAGE_W-1:0]        page_i,
    input  logic [ADDR_W-1:0]        addr_i,
    input  xfer_width_e              width_i,
    output logic [PAGE_W+ADDR_W-1:0] phys_o
);
    always_comb begin
        if (width_i == XFER_WORD) phys_o = {page_i[PAGE_W-1:1], addr_i, 1'b0};
        else                      phys_o = {page_i, addr_i};
    end
endmodule

// File: rtl/dma_addr_seq.sv
module dma_addr_seq
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int PAGE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_i,
    input  logic [ADDR_W-1:0]        base_addr_i,
    input  logic [CNT_W-1:0]         base_cnt_i,
    input  logic                     page_we_i,
    input  logic [PAGE_W-1:0]        page_i,
    input  logic                     word_mode_i,
    input  logic                     step_down_i,
    input  logic                     auto_init_i,
    input  logic                     xfer_done_i,
    output logic [PAGE_W+ADDR_W-1:0] phys_addr_o,
    output logic [CNT_W-1:0]         remain_cnt_o,
    output logic                     tc_o,
    output logic                     masked_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] base_addr;
        logic [CNT_W-1:0]  base_cnt;
        logic [ADDR_W-1:0] cur_addr;
        logic [CNT_W-1:0]  cur_cnt;
        logic [PAGE_W-1:0] page;
        logic              masked;
        logic              tc;
    } seq_state_t;

    seq_state_t st_d, st_q;

    logic [ADDR_W-1:0] addr_step;
    logic [CNT_W-1:0]  cnt_step;
    logic              cnt_zero;
    logic              accept;
    step_dir_e         dir;
    xfer_width_e       width;

    // named views of state for the bound checker
    logic [ADDR_W-1:0] cur_addr_q;
    logic [PAGE_W-1:0] page_q;
    assign cur_addr_q = st_q.cur_addr;
    assign page_q     = st_q.page;

    assign dir    = step_down_i ? STEP_DOWN : STEP_UP;
    assign width  = word_mode_i ? XFER_WORD : XFER_BYTE;
    assign accept = xfer_done_i & ~st_q.masked;

    dma_addr_step #(.ADDR_W(ADDR_W)) u_addr_step (
        .addr_i (st_q.cur_addr),
        .dir_i  (dir),
        .addr_o (addr_step)
    );

    dma_cnt_step #(.CNT_W(CNT_W)) u_cnt_step (
        .cnt_i  (st_q.cur_cnt),
        .cnt_o  (cnt_step),
        .zero_o (cnt_zero)
    );

    dma_phys_map #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_phys_map (
        .page_i  (st_q.page),
        .addr_i  (st_q.cur_addr),
        .width_i (width),
        .phys_o  (phys_addr_o)
    );

    always_comb begin
        st_d    = st_q;
        st_d.tc = 1'b0;
        if (page_we_i) begin
            st_d.page = page_i;
        end
        if (load_i) begin
            st_d.base_addr = base_addr_i;
            st_d.base_cnt  = base_cnt_i;
            st_d.cur_addr  = base_addr_i;
            st_d.cur_cnt   = base_cnt_i;
            st_d.masked    = 1'b0;
        end else if (accept) begin
            st_d.tc = cnt_zero;
            if (cnt_zero && auto_init_i) begin
                st_d.cur_addr = st_q.base_addr;
                st_d.cur_cnt  = st_q.base_cnt;
            end else begin
                st_d.cur_addr = addr_step;
                st_d.cur_cnt  = cnt_step;
                if (cnt_zero) begin
                    st_d.masked = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.masked <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign remain_cnt_o = st_q.cur_cnt;
    assign tc_o         = st_q.tc;
    assign masked_o     = st_q.masked;
endmodule

// File: rtl/dma_addr_seq_chk.sv
module dma_addr_seq_chk #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int PAGE_W = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     load_i,
    input logic                     page_we_i,
    input logic                     word_mode_i,
    input logic                     step_down_i,
    input logic                     auto_init_i,
    input logic                     xfer_done_i,
    input logic [ADDR_W-1:0]        cur_addr_q,
    input logic [PAGE_W-1:0]        page_q,
    input logic [PAGE_W+ADDR_W-1:0] phys_addr_o,
    input logic [CNT_W-1:0]         remain_cnt_o,
    input logic                     tc_o,
    input logic                     masked_o
);
    logic take;
    logic last;
    assign take = xfer_done_i && !masked_o && !load_i;
    assign last = take && (remain_cnt_o == '0);

    AST_BYTE_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        !word_mode_i |-> phys_addr_o == {page_q, cur_addr_q}); // R1

    AST_ADDR_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !step_down_i && !(last && auto_init_i)) |=>
        cur_addr_q == ADDR_W'($past(cur_addr_q) + ADDR_W'(1))); // R1

    AST_CNT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !last) |=> remain_cnt_o == CNT_W'($past(remain_cnt_o) - CNT_W'(1))); // R2

    AST_WORD_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        word_mode_i |-> phys_addr_o == {page_q[PAGE_W-1:1], cur_addr_q, 1'b0}); // R3

    AST_TC_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        tc_o |-> $past(last)); // R4

    AST_TC_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> tc_o); // R4

    AST_AUTO_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (last && auto_init_i) |=> !masked_o); // R5

    AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !auto_init_i) |=> masked_o); // R6

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (masked_o && !load_i) |=> $stable(cur_addr_q) && $stable(remain_cnt_o)); // R6

    AST_ADDR_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (take && step_down_i && !(last && auto_init_i)) |=>
        cur_addr_q == ADDR_W'($past(cur_addr_q) - ADDR_W'(1))); // R7

    AST_LOAD_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> !masked_o && !tc_o); // R8

    AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !page_we_i |=> $stable(page_q)); // R8
endmodule

bind dma_addr_seq dma_addr_seq_chk #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PAGE_W(PAGE_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (load_i),
    .page_we_i    (page_we_i),
    .word_mode_i  (word_mode_i),
    .step_down_i  (step_down_i),
    .auto_init_i  (auto_init_i),
    .xfer_done_i  (xfer_done_i),
    .cur_addr_q   (cur_addr_q),
    .page_q       (page_q),
    .phys_addr_o  (phys_addr_o),
    .remain_cnt_o (remain_cnt_o),
    .tc_o         (tc_o),
    .masked_o     (masked_o)
);

// File: tb/dma_addr_seq_bench.sv
module dma_addr_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_i = 1'b0;
    logic [15:0] base_addr_i = '0;
    logic [15:0] base_cnt_i = '0;
    logic        page_we_i = 1'b0;
    logic [7:0]  page_i = '0;
    logic        word_mode_i = 1'b0;
    logic        step_down_i = 1'b0;
    logic        auto_init_i = 1'b0;
    logic        xfer_done_i = 1'b0;
    logic [23:0] phys_addr_o;
    logic [15:0] remain_cnt_o;
    logic        tc_o;
    logic        masked_o;

    int checks = 0;
    int failures = 0;

    // reference model state
    logic [15:0] m_base_a = '0, m_base_c = '0, m_addr = '0, m_cnt = '0;
    logic [7:0]  m_page = '0;
    logic        m_mask = 1'b1, m_tc = 1'b0;

    always #4 clk = ~clk;

    dma_addr_seq u_dma_addr_seq (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .base_addr_i(base_addr_i),
        .base_cnt_i(base_cnt_i), .page_we_i(page_we_i), .page_i(page_i),
        .word_mode_i(word_mode_i), .step_down_i(step_down_i),
        .auto_init_i(auto_init_i), .xfer_done_i(xfer_done_i),
        .phys_addr_o(phys_addr_o), .remain_cnt_o(remain_cnt_o),
        .tc_o(tc_o), .masked_o(masked_o)
    );

    function automatic logic [23:0] exp_phys(input logic w, input logic [7:0] pg,
                                             input logic [15:0] a);
        if (w) return {pg[7:1], a, 1'b0};
        return {pg, a};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // one cycle: drive at negedge, model at posedge, compare shortly after
    task automatic cyc(input logic ld, input logic [15:0] la, input logic [15:0] lc,
                       input logic pwe, input logic [7:0] pv, input logic xf);
        load_i = ld; base_addr_i = la; base_cnt_i = lc;
        page_we_i = pwe; page_i = pv; xfer_done_i = xf;
        @(posedge clk);
        m_tc = 1'b0;
        if (pwe) m_page = pv;
        if (ld) begin
            m_base_a = la; m_base_c = lc; m_addr = la; m_cnt = lc; m_mask = 1'b0;
        end else if (xf && !m_mask) begin
            m_tc = (m_cnt == 16'h0000);
            if (m_tc && auto_init_i) begin
                m_addr = m_base_a; m_cnt = m_base_c;
            end else begin
                m_addr = step_down_i ? m_addr - 16'd1 : m_addr + 16'd1;
                m_cnt  = m_cnt - 16'd1;
                if (m_tc) m_mask = 1'b1;
            end
        end
        #2;
        chk(word_mode_i ? "R3" : (step_down_i ? "R7" : "R1"),
            32'(phys_addr_o), 32'(exp_phys(word_mode_i, m_page, m_addr)));
        chk("R2", 32'(remain_cnt_o), 32'(m_cnt));
        chk("R4", 32'(tc_o), 32'(m_tc));
        chk(auto_init_i ? "R5" : "R6", 32'(masked_o), 32'(m_mask));
        @(negedge clk);
        load_i = 1'b0; page_we_i = 1'b0; xfer_done_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9", 32'(phys_addr_o), 32'h0);
        chk("R9", 32'(remain_cnt_o), 32'h0);
        chk("R9", 32'(tc_o), 32'h0);
        chk("R9", 32'(masked_o), 32'h1);
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R2/R4/R6: byte mode, upward wrap, 4 transfers from count 3
        cyc(1'b0, 16'h0, 16'h0, 1'b1, 8'h12, 1'b0);
        cyc(1'b1, 16'hFFFE, 16'd3, 1'b0, 8'h0, 1'b0);
        cyc(1'b0, 16'h0, 16'h0, 1'b0, 8'h0, 1'b1);
        cyc(1'b0, 16'h0, 16'h0, 1'b0, 8'h0, 1'b1);
        chk("R1", 32'(phys_addr_o), 32'h120000);
        cyc(1'b0, 16'h0, 16'h0, 1'b0, 8'h0, 1'b1);
        chk("R4", 32'(tc_o), 32'h0);
        cyc(1'b0, 16'h0, 16'h0, 1'b0, 8'h0, 1'b1);
        chk("R2", 32'(remain_cnt_o), 32'hFFFF);
        chk("R4", 32'(tc_o), 32'h1);
        chk("R6", 32'(masked_o), 32'h1);
        cyc(1'b0, 16'h0, 16'h0, 1'b0, 8'h0, 1'b1);
        chk("R6", 32'(remain_cnt_o), 32'hFFFF);
        chk("R6", 32'(phys_addr_o), 32'h120002);
        chk("R4", 32'(tc_o), 32'h0);

        // R3: word mode, page bit 0 ignored
        word_mode_i = 1'b1;
        cyc(1'b1, 16'h8000, 16'd0, 1'b1, 8'h13, 1'b0);
        chk("R3", 32'(phys_addr_o), 32'h130000);
        cyc(1'b0, 16'h0, 16'h0, 1'b1, 8'h12, 1'b0);
        chk("R3", 32'(phys_addr_o), 32'h130000);

        // R7: downward wrap inside the page
        word_mode_i = 1'b0; step_down_i = 1'b1;
        cyc(1'b1, 16'h0001, 16'd5, 1'b0, 8'h0, 1'b0);
        cyc(1'b0, 16'h0, 16'h0, 1'b0, 8'h0, 1'b1);
        cyc(1'b0, 16'h0, 16'h0, 1'b0, 8'h0, 1'b1);
        chk("R7", 32'(phys_addr_o), 32'h12FFFF);

        // R5: auto-initialise reload
        step_down_i = 1'b0; auto_init_i = 1'b1;
        cyc(1'b1, 16'h0100, 16'd1, 1'b0, 8'h0, 1'b0);
        cyc(1'b0, 16'h0, 16'h0, 1'b0, 8'h0, 1'b1);
        cyc(1'b0, 16'h0, 16'h0, 1'b0, 8'h0, 1'b1);
        chk("R5", 32'(tc_o), 32'h1);
        chk("R5", 32'(remain_cnt_o), 32'h1);
        chk("R5", 32'(phys_addr_o), 32'h120100);
        chk("R5", 32'(masked_o), 32'h0);

        // R8: load wins over a same-cycle strobe
        auto_init_i = 1'b0;
        cyc(1'b1, 16'h0200, 16'd7, 1'b0, 8'h0, 1'b1);
        chk("R8", 32'(remain_cnt_o), 32'h7);
        chk("R8", 32'(phys_addr_o), 32'h120200);

        // random phase; modes change only with a load
        for (int i = 0; i < 4000; i++) begin
            logic        ld;
            logic [15:0] la, lc;
            ld = ($urandom % 20) == 0;
            la = 16'($urandom);
            lc = (($urandom % 4) == 0) ? 16'($urandom) : 16'($urandom % 24);
            if (ld) begin
                word_mode_i = 1'($urandom);
                step_down_i = 1'($urandom);
                auto_init_i = 1'($urandom);
            end
            cyc(ld, la, lc, ($urandom % 25) == 0, 8'($urandom), 1'($urandom));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule